// File: doc/BRIEF.md
# Register-Offset Load/Store Operand Legality Checker

This block inspects one decoded load or store that takes its address from a base register plus an offset register. It reports whether the combination of operand registers is forbidden, has unpredictable results, or is allowed but discouraged. The decoder sends the four register numbers along with the access attributes: addressing mode, access size, load or store, single or paired (doubleword) transfer, encoding class and a legacy-architecture flag. One clock edge later the block returns three independent severity flags and a rule number. Executing the access is done elsewhere.

The rules are numbered 1 to 19 and grouped by severity. Rules 1–13 are *illegal*, 14–15 are *unpredictable* and 16–19 are *deprecated*. The reported rule number is the lowest-numbered rule that fires. Because the numbering follows severity, the reported rule always belongs to the most severe class present. Rule number 0 means that no rule fired.

Encodings. Mode: 0 = plain offset (no writeback), 1 = pre-indexed, 2 = post-indexed, 3 = treated as a writeback form. Size: 0 = word, and any other value is a sub-word size. Class: 0 = full-width, 1 = 32-bit compressed, and 2 or 3 = 16-bit compressed. Register numbers 12, 13, 14 and 15 are IP, SP, LR and PC. The block has no state machine. Its only storage is the output register, which is cleared by reset.

Top module: `ldst_operand_checker`

## Requirements
- R1: While reset is asserted all outputs are zero. Every result is registered, so it appears on the outputs after the first rising clock edge that follows the input change.
- R2: An offset register of 15 is illegal (rule 1), whatever the class.
- R3: In a writeback mode (mode not 0), a base equal to the transfer register is illegal (rule 2). A base equal to the offset register is illegal only when the legacy flag is 1 (rule 3).
- R4: In the 16-bit class, a transfer, base or offset register above 7 is illegal (rule 4).
- R5: For a full-width doubleword, an odd first register (rule 5), a first register of 14 (rule 6) or a second register other than first+1 (rule 7) is illegal.
- R6: For a full-width doubleword load, an offset register equal to either transfer register is illegal (rule 8). For any full-width doubleword in a writeback mode, a base equal to the second register is illegal (rule 9).
- R7: For a 32-bit compressed doubleword, either transfer register being 13 or 15 is illegal (rule 10).
- R8: In the full-width class, a base of 15 in a writeback mode is illegal (rule 11). A transfer register of 15 with a sub-word size is illegal (rule 12).
- R9: In the compressed classes, register 15 is illegal anywhere except as the transfer register of a single word load (rule 13).
- R10: In the compressed classes, an offset register of 13 (rule 14) and a transfer register of 13 with a sub-word size (rule 15) are unpredictable.
- R11: In the full-width class, a store with transfer or base register 15 (rule 16), an offset register of 13 (rule 17) and a transfer register of 13 with a sub-word size (rule 18) are deprecated.
- R12: A full-width doubleword whose first register is 12 is deprecated only (rule 19).
- R13: Each flag is set when any rule of its class fires, independently of the others. The rule number is the lowest firing rule, or 0 with all flags clear when nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt | input | 4 | Transfer (first) register |
| rt2 | input | 4 | Second transfer register for doubleword |
| rn | input | 4 | Base register |
| rm | input | 4 | Offset register |
| mode | input | 2 | Addressing mode code |
| size | input | 2 | Access size code, 0 = word |
| is_load | input | 1 | 1 = load, 0 = store |
| is_dual | input | 1 | Doubleword transfer |
| enc_class | input | 2 | Encoding class code |
| legacy_arch | input | 1 | Older architecture, forbids base/offset alias under writeback |
| illegal | output | 1 | An illegal rule fired |
| unpredictable | output | 1 | An unpredictable rule fired |
| deprecated | output | 1 | A deprecated rule fired |
| reason | output | 5 | Lowest firing rule number, 0 if none |

## Verification
All four outputs belong to the same operand set and are due together, exactly one rising edge after the inputs are applied. There is no other pipeline stage, so no result arrives earlier or later. The bench changes the inputs on a falling edge, lets one rising edge pass, and samples on the following falling edge. That sample sees only the registered result of that one operand set. The bound assertions compare the outputs with the inputs as they were one cycle earlier, and they start only after the first clock edge out of reset.

// File: rtl/ldst_legal_pkg.sv
package ldst_legal_pkg;

    localparam int REG_W        = 4;
    localparam int NUM_RULES    = 19;
    localparam int CODE_W       = $clog2(NUM_RULES + 1);
    localparam int LAST_ILLEGAL = 13;
    localparam int LAST_UNPRED  = 15;

    localparam logic [REG_W-1:0] REG_IP  = REG_W'(12);
    localparam logic [REG_W-1:0] REG_SP  = REG_W'(13);
    localparam logic [REG_W-1:0] REG_LR  = REG_W'(14);
    localparam logic [REG_W-1:0] REG_PC  = REG_W'(15);
    localparam logic [REG_W-1:0] LOW_TOP = REG_W'(7);

    typedef enum logic [1:0] {
        MODE_OFFSET = 2'd0,
        MODE_PRE    = 2'd1,
        MODE_POST   = 2'd2,
        MODE_RSVD   = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        EC_FULL   = 2'd0,
        EC_WIDE   = 2'd1,
        EC_NARROW = 2'd2,
        EC_NARROW_ALT = 2'd3
    } enc_class_e;

    typedef enum logic [1:0] {
        SEV_ILLEGAL,
        SEV_UNPRED,
        SEV_DEPREC
    } severity_e;

    typedef struct packed {
        logic              wb;
        logic              word;
        logic              load;
        logic              dual;
        logic              full;
        logic              wide;
        logic              narrow;
        logic              old;
    } attr_t;

    typedef struct packed {
        logic              illegal;
        logic              unpred;
        logic              deprec;
        logic [CODE_W-1:0] reason;
    } verdict_t;

    function automatic severity_e rule_severity(input int idx);
        if (idx <= LAST_ILLEGAL)     return SEV_ILLEGAL;
        else if (idx <= LAST_UNPRED) return SEV_UNPRED;
        else                         return SEV_DEPREC;
    endfunction

endpackage

// File: rtl/ldst_field_decode.sv
module ldst_field_decode
    import ldst_legal_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] size,
    input  logic       is_load,
    input  logic       is_dual,
    input  logic [1:0] enc_class,
    input  logic       legacy_arch,
    output attr_t      attr
);

    addr_mode_e mode_e;
    enc_class_e class_e;

    always_comb begin
        mode_e  = addr_mode_e'(mode);
        class_e = enc_class_e'(enc_class);
        attr    = '0;
        attr.wb   = (mode_e != MODE_OFFSET);
        attr.word = (size == 2'd0);
        attr.load = is_load;
        attr.dual = is_dual;
        attr.old  = legacy_arch;
        unique case (class_e)
            EC_FULL:       attr.full   = 1'b1;
            EC_WIDE:       attr.wide   = 1'b1;
            EC_NARROW,
            EC_NARROW_ALT: attr.narrow = 1'b1;
        endcase
    end

endmodule

// File: rtl/ldst_rule_eval.sv
module ldst_rule_eval
    import ldst_legal_pkg::*;
(
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] rt2,
    input  logic [REG_W-1:0] rn,
    input  logic [REG_W-1:0] rm,
    input  attr_t            attr,
    output logic [NUM_RULES:1] hit
);

    logic [REG_W-1:0] rt_succ;
    logic             packed_cls;
    logic             full_dw;
    logic             pc_any_misuse;

    assign rt_succ    = rt + 1'b1;
    assign packed_cls = attr.wide | attr.narrow;
    assign full_dw    = attr.full & attr.dual;

    always_comb begin
        pc_any_misuse = (rn == REG_PC)
                      | ((rt == REG_PC) & ~(attr.load & attr.word & ~attr.dual))
                      | (attr.dual & (rt2 == REG_PC));
    end

    always_comb begin
        hit = '0;
        // illegal group
        hit[1]  = (rm == REG_PC);
        hit[2]  = attr.wb & (rn == rt);
        hit[3]  = attr.wb & attr.old & (rn == rm);
        hit[4]  = attr.narrow & ((rt > LOW_TOP) | (rn > LOW_TOP) | (rm > LOW_TOP));
        hit[5]  = full_dw & rt[0];
        hit[6]  = full_dw & (rt == REG_LR);
        hit[7]  = full_dw & (rt2 != rt_succ);
        hit[8]  = full_dw & attr.load & ((rm == rt) | (rm == rt2));
        hit[9]  = full_dw & attr.wb & (rn == rt2);
        hit[10] = attr.wide & attr.dual &
                  ((rt == REG_SP) | (rt == REG_PC) | (rt2 == REG_SP) | (rt2 == REG_PC));
        hit[11] = attr.full & attr.wb & (rn == REG_PC);
        hit[12] = attr.full & ~attr.word & (rt == REG_PC);
        hit[13] = packed_cls & pc_any_misuse;
        // unpredictable group
        hit[14] = packed_cls & (rm == REG_SP);
        hit[15] = packed_cls & ~attr.word & (rt == REG_SP);
        // deprecated group
        hit[16] = attr.full & ~attr.load & ((rt == REG_PC) | (rn == REG_PC));
        hit[17] = attr.full & (rm == REG_SP);
        hit[18] = attr.full & ~attr.word & (rt == REG_SP);
        hit[19] = full_dw & (rt == REG_IP);
    end

endmodule

// File: rtl/ldst_rule_arbiter.sv
module ldst_rule_arbiter
    import ldst_legal_pkg::*;
(
    input  logic [NUM_RULES:1] hit,
    output verdict_t           verdict
);

    logic [NUM_RULES:1] ill_mask;
    logic [NUM_RULES:1] unp_mask;
    logic [NUM_RULES:1] dep_mask;

    for (genvar g = 1; g <= NUM_RULES; g++) begin : g_mask
        assign ill_mask[g] = (rule_severity(g) == SEV_ILLEGAL);
        assign unp_mask[g] = (rule_severity(g) == SEV_UNPRED);
        assign dep_mask[g] = (rule_severity(g) == SEV_DEPREC);
    end

    always_comb begin
        verdict         = '0;
        verdict.illegal = |(hit & ill_mask);
        verdict.unpred  = |(hit & unp_mask);
        verdict.deprec  = |(hit & dep_mask);
        for (int i = NUM_RULES; i >= 1; i--) begin
            if (hit[i]) verdict.reason = CODE_W'(i);
        end
    end

endmodule

// File: rtl/ldst_operand_checker.sv
module ldst_operand_checker
    import ldst_legal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  rt,
    input  logic [3:0]  rt2,
    input  logic [3:0]  rn,
    input  logic [3:0]  rm,
    input  logic [1:0]  mode,
    input  logic [1:0]  size,
    input  logic        is_load,
    input  logic        is_dual,
    input  logic [1:0]  enc_class,
    input  logic        legacy_arch,
    output logic        illegal,
    output logic        unpredictable,
    output logic        deprecated,
    output logic [4:0]  reason
);

    attr_t              attr;
    logic [NUM_RULES:1] hit;
    verdict_t           verdict_d;
    verdict_t           verdict_q;

    ldst_field_decode u_decode (
        .mode        (mode),
        .size        (size),
        .is_load     (is_load),
        .is_dual     (is_dual),
        .enc_class   (enc_class),
        .legacy_arch (legacy_arch),
        .attr        (attr)
    );

    ldst_rule_eval u_eval (
        .rt   (rt),
        .rt2  (rt2),
        .rn   (rn),
        .rm   (rm),
        .attr (attr),
        .hit  (hit)
    );

    ldst_rule_arbiter u_arb (
        .hit     (hit),
        .verdict (verdict_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    always_comb begin
        illegal       = verdict_q.illegal;
        unpredictable = verdict_q.unpred;
        deprecated    = verdict_q.deprec;
        reason        = verdict_q.reason;
    end

endmodule

// File: rtl/ldst_operand_chk.sv
module ldst_operand_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] rt,
    input logic [3:0] rn,
    input logic [3:0] rm,
    input logic [1:0] mode,
    input logic [1:0] enc_class,
    input logic       illegal,
    input logic       unpredictable,
    input logic       deprecated,
    input logic [4:0] reason
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (reason == 5'd0));

    p_rm_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rm) == 4'd15) |-> (illegal && reason == 5'd1));

    p_wb_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode) != 2'd0 && $past(rn) == $past(rt)) |-> illegal);

    p_narrow_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(enc_class[1]) && $past(rt) > 4'd7) |-> illegal);

    p_illegal_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (reason >= 5'd1 && reason <= 5'd13));

    p_unpred_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (unpredictable && !illegal) |-> (reason == 5'd14 || reason == 5'd15));

    p_clean_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (reason == 5'd0) |-> (!illegal && !unpredictable && !deprecated));

endmodule

bind ldst_operand_checker ldst_operand_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rt            (rt),
    .rn            (rn),
    .rm            (rm),
    .mode          (mode),
    .enc_class     (enc_class),
    .illegal       (illegal),
    .unpredictable (unpredictable),
    .deprecated    (deprecated),
    .reason        (reason)
);

// File: tb/sim_ldst_operand_checker.sv
module sim_ldst_operand_checker;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rt = '0, rt2 = '0, rn = '0, rm = '0;
    logic [1:0] mode = '0, size = '0, enc_class = '0;
    logic       is_load = 1'b0, is_dual = 1'b0, legacy_arch = 1'b0;
    logic       illegal, unpredictable, deprecated;
    logic [4:0] reason;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_operand_checker u0 (
        .clk(clk), .rst_n(rst_n), .rt(rt), .rt2(rt2), .rn(rn), .rm(rm),
        .mode(mode), .size(size), .is_load(is_load), .is_dual(is_dual),
        .enc_class(enc_class), .legacy_arch(legacy_arch),
        .illegal(illegal), .unpredictable(unpredictable),
        .deprecated(deprecated), .reason(reason)
    );

    // Independent reference: returns {illegal, unpred, deprec, reason[4:0]}
    function automatic logic [7:0] model(
        input logic [3:0] a_rt, a_rt2, a_rn, a_rm,
        input logic [1:0] a_mode, a_size, input logic a_ld, a_dw,
        input logic [1:0] a_cls, input logic a_old);
        logic [19:1] f;
        logic wb, wd, fu, wi, na, cp;
        logic [4:0] code;
        wb = a_mode != 0; wd = a_size == 0;
        fu = a_cls == 0; wi = a_cls == 1; na = a_cls >= 2; cp = !fu;
        f = '0;
        if (a_rm == 15) f[1] = 1;
        if (wb && a_rn == a_rt) f[2] = 1;
        if (wb && a_old && a_rn == a_rm) f[3] = 1;
        if (na && (a_rt >= 8 || a_rn >= 8 || a_rm >= 8)) f[4] = 1;
        if (fu && a_dw) begin
            f[5] = a_rt % 2 == 1;
            f[6] = a_rt == 14;
            f[7] = {1'b0, a_rt2} != {1'b0, a_rt} + 5'd1;
            f[8] = a_ld && (a_rm == a_rt || a_rm == a_rt2);
            f[9] = wb && a_rn == a_rt2;
            f[19] = a_rt == 12;
        end
        if (wi && a_dw && (a_rt >= 13 && a_rt != 14 || a_rt2 >= 13 && a_rt2 != 14)) f[10] = 1;
        if (fu && wb && a_rn == 15) f[11] = 1;
        if (fu && !wd && a_rt == 15) f[12] = 1;
        if (cp && (a_rn == 15 || (a_dw && a_rt2 == 15) ||
                   (a_rt == 15 && !(a_ld && wd && !a_dw)))) f[13] = 1;
        if (cp && a_rm == 13) f[14] = 1;
        if (cp && !wd && a_rt == 13) f[15] = 1;
        if (fu && !a_ld && (a_rt == 15 || a_rn == 15)) f[16] = 1;
        if (fu && a_rm == 13) f[17] = 1;
        if (fu && !wd && a_rt == 13) f[18] = 1;
        code = 0;
        for (int k = 19; k >= 1; k--) if (f[k]) code = 5'(k);
        return {|f[13:1], |f[15:14], |f[19:16], code};
    endfunction

    task automatic apply_and_check(
        input string tag,
        input logic [3:0] a_rt, a_rt2, a_rn, a_rm,
        input logic [1:0] a_mode, a_size, input logic a_ld, a_dw,
        input logic [1:0] a_cls, input logic a_old,
        input logic [7:0] expv);
        logic [7:0] got;
        @(negedge clk);
        rt = a_rt; rt2 = a_rt2; rn = a_rn; rm = a_rm; mode = a_mode;
        size = a_size; is_load = a_ld; is_dual = a_dw;
        enc_class = a_cls; legacy_arch = a_old;
        @(posedge clk);
        @(negedge clk);
        got = {illegal, unpredictable, deprecated, reason};
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got ill/unp/dep=%b%b%b code=%0d expected %b%b%b code=%0d",
                     tag, got[7], got[6], got[5], got[4:0],
                     expv[7], expv[6], expv[5], expv[4:0]);
        end
    endtask

    // flags then rule number
    function automatic logic [7:0] v(input logic i, u, d, input int c);
        return {i, u, d, 5'(c)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        got = {illegal, unpredictable, deprecated, reason};
        n_checks++;
        if (got !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: reset outputs got %h expected 00", got);
        end
        rst_n = 1'b1;

        // tag, rt, rt2, rn, rm, mode, size, ld, dw, cls, old, expected
        apply_and_check("R13 clean",      0, 0, 1, 2, 0, 0, 1, 0, 0, 0, v(0,0,0,0));
        apply_and_check("R2 rm pc",       0, 0, 1, 15,0, 0, 1, 0, 0, 0, v(1,0,0,1));
        apply_and_check("R3 rn=rt pre",   3, 0, 3, 4, 1, 0, 1, 0, 0, 0, v(1,0,0,2));
        apply_and_check("R3 rn=rm old",   1, 0, 5, 5, 2, 0, 1, 0, 0, 1, v(1,0,0,3));
        apply_and_check("R3 rn=rm new",   1, 0, 5, 5, 2, 0, 1, 0, 0, 0, v(0,0,0,0));
        apply_and_check("R4 narrow hi",   8, 0, 1, 2, 0, 0, 1, 0, 2, 0, v(1,0,0,4));
        apply_and_check("R4 narrow lo",   7, 0, 1, 2, 0, 0, 1, 0, 3, 0, v(0,0,0,0));
        apply_and_check("R5 odd rt",      3, 4, 0, 1, 0, 0, 1, 1, 0, 0, v(1,0,0,5));
        apply_and_check("R5 rt lr",       14,15,0, 1, 0, 0, 0, 1, 0, 0, v(1,0,0,6));
        apply_and_check("R5 bad pair",    2, 5, 0, 1, 0, 0, 1, 1, 0, 0, v(1,0,0,7));
        apply_and_check("R6 rm=rt2 load", 2, 3, 0, 3, 0, 0, 1, 1, 0, 0, v(1,0,0,8));
        apply_and_check("R6 rm=rt2 store",2, 3, 0, 3, 0, 0, 0, 1, 0, 0, v(0,0,0,0));
        apply_and_check("R6 rn=rt2 wb",   2, 3, 3, 1, 1, 0, 0, 1, 0, 0, v(1,0,0,9));
        apply_and_check("R7 wide dw sp",  12,13,0, 1, 0, 0, 1, 1, 1, 0, v(1,0,0,10));
        apply_and_check("R8 pc base wb",  0, 0, 15,1, 1, 0, 1, 0, 0, 0, v(1,0,0,11));
        apply_and_check("R8 pc base off", 0, 0, 15,1, 0, 0, 1, 0, 0, 0, v(0,0,0,0));
        apply_and_check("R8 pc rt byte",  15,0, 0, 1, 0, 1, 1, 0, 0, 0, v(1,0,0,12));
        apply_and_check("R9 pc word ld",  15,0, 0, 1, 0, 0, 1, 0, 1, 0, v(0,0,0,0));
        apply_and_check("R9 pc store",    15,0, 0, 1, 0, 0, 0, 0, 1, 0, v(1,0,0,13));
        apply_and_check("R9 pc base",     0, 0, 15,1, 0, 0, 1, 0, 1, 0, v(1,0,0,13));
        apply_and_check("R10 sp rm",      0, 0, 1, 13,0, 0, 1, 0, 1, 0, v(0,1,0,14));
        apply_and_check("R10 sp rt half", 13,0, 1, 2, 0, 2, 1, 0, 1, 0, v(0,1,0,15));
        apply_and_check("R10 sp rt word", 13,0, 1, 2, 0, 0, 1, 0, 1, 0, v(0,0,0,0));
        apply_and_check("R11 pc store",   15,0, 0, 1, 0, 0, 0, 0, 0, 0, v(0,0,1,16));
        apply_and_check("R11 sp rm",      0, 0, 1, 13,0, 0, 1, 0, 0, 0, v(0,0,1,17));
        apply_and_check("R11 sp rt half", 13,0, 1, 2, 0, 2, 1, 0, 0, 0, v(0,0,1,18));
        apply_and_check("R12 r12 pair",   12,13,0, 1, 0, 0, 1, 1, 0, 0, v(0,0,1,19));
        apply_and_check("R13 ill+dep",    2, 0, 2, 13,1, 0, 1, 0, 0, 0, v(1,0,1,2));
        apply_and_check("R13 two unp",    13,0, 1, 13,0, 1, 1, 0, 1, 0, v(0,1,0,14));

        begin
            void'($urandom(32'h5EED_1234));
            for (int n = 0; n < 1500; n++) begin
                logic [3:0] a, b, c, d;
                logic [1:0] md, sz, cl;
                logic ld, dw, od;
                a = 4'($urandom); b = 4'($urandom); c = 4'($urandom); d = 4'($urandom);
                md = 2'($urandom); sz = 2'($urandom); cl = 2'($urandom);
                ld = 1'($urandom); dw = 1'($urandom); od = 1'($urandom);
                if ($urandom_range(0, 3) == 0) b = a + 4'd1;
                apply_and_check("R13 random", a, b, c, d, md, sz, ld, dw, cl, od,
                                model(a, b, c, d, md, sz, ld, dw, cl, od));
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule